// File: doc/BRIEF.md
# Lookahead Critical-Queue Head Cache Manager

This block keeps track of a small on-chip head cache that sits in front of a slow, wide bulk memory in a multi-queue packet buffer. Every cell slot an arbiter may ask for one cell and names the queue it wants. The block does not serve that request at once. It places the request in a lookahead window that spans the next `Q*(B-1)+1` slots. When the window is full, the request leaves it as a dispatch, and that cell is read from the head cache.

The bulk memory moves whole blocks of `B` cells of one queue, and a transfer occupies `B` slots. Whenever the bulk port is free, the block scans the window from the dispatch end. For each queue it works out at which position the pending requests would use up the cells that the queue has cached or already in flight. It then asks the bulk memory to refill the queue that would run dry first. If no queue runs dry inside the window, it asks for nothing.

The tail side reports each block of `B` cells written into bulk memory. The block refuses requests for cells that have never entered the buffer. A dispatch that finds its queue's cache empty sets a sticky error flag.

Top module: `lookahead_head_cache`

## Requirements
- R1: While reset is low and in the first slot after it, no dispatch and no refill request is raised, the error flag is low, and no queue holds any cells.
- R2: `req_ready` is 1 only when the queue named by `req_queue` holds cells that no earlier accepted request has claimed. A request made with `req_ready` at 0 is dropped, and it produces no dispatch.
- R3: An accepted request made in slot t is dispatched in slot t+Q*(B-1)+1 with the same queue number. A slot with no accepted request produces a slot with no dispatch.
- R4: Credit means cached cells plus in-flight cells. When the bulk port is free, the refill goes to the queue whose running count of pending requests, counted from the dispatch end of the window, first exceeds its credit.
- R5: When no eligible queue's pending requests exceed its credit anywhere in the window, no refill request is made.
- R6: Two refill requests are always at least B slots apart.
- R7: `arrive_valid` adds one block of B cells to the bulk count of `arrive_queue`. Only a queue whose bulk count is at least B may be chosen for a refill. Each refill takes B cells from the bulk count and adds B cells to the in-flight count.
- R8: Cells in flight count toward a queue's credit. A queue that has a block on its way is therefore not chosen again for that same shortfall.
- R9: `fill_valid` moves B cells of `fill_queue` from in-flight into the cache. A dispatch of a cell that arrives in the same slot is served. A dispatch that finds no cell sets `err_empty`, and the flag stays set until reset.
- R10: When requests are spaced at least B slots apart and the bulk memory answers every refill one slot later, `err_empty` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arrive_valid | input | 1 | One block of B cells was written to bulk memory |
| arrive_queue | input | QW | Queue of the written block |
| req_valid | input | 1 | Arbiter requests one cell this slot |
| req_queue | input | QW | Queue of the requested cell |
| req_ready | output | 1 | The named queue has unclaimed cells, so the request is taken |
| disp_valid | output | 1 | A cell is dispatched from the head cache this slot |
| disp_queue | output | QW | Queue of the dispatched cell |
| repl_valid | output | 1 | Refill request to bulk memory |
| repl_queue | output | QW | Queue to refill with B cells |
| fill_valid | input | 1 | Bulk memory delivers B cells this slot |
| fill_queue | input | QW | Queue of the delivered cells |
| err_empty | output | 1 | Sticky flag: a dispatch found its queue's cache empty |

## Verification
The bench builds the block with Q=4 and B=4. That makes the window 13 slots deep, so a request reaches dispatch within a few slots of being made. It also means both the warm-up, when every cache is empty, and the steady state are reached inside a short run. The bench's responder answers each refill one slot later, and on demand it drops the answer, which is how it provokes the empty-cache error. Four queues give enough contention for the earliest-shortfall choice and its skipping of ineligible queues to differ visibly from choosing by occupancy.

// File: rtl/lacm_pkg.sv
package lacm_pkg;
  // Width of an index over n items, never below one bit.
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/lacm_window.sv
module lacm_window #(
  parameter int DEPTH = 13,
  parameter int QW    = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  push_v,
  input  logic [QW-1:0]         push_q,
  output logic [DEPTH-1:0]      win_v,
  output logic [DEPTH*QW-1:0]   win_q
);
  // Position 0 is the dispatch end; new requests enter at DEPTH-1.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_v <= '0;
      win_q <= '0;
    end else begin
      win_v <= {push_v, win_v[DEPTH-1:1]};
      win_q <= {push_q, win_q[DEPTH*QW-1:QW]};
    end
  end
endmodule

// File: rtl/lacm_pick.sv
module lacm_pick #(
  parameter int Q     = 4,
  parameter int DEPTH = 13,
  parameter int QW    = 2,
  parameter int CW    = 9,
  parameter int PW    = 4
) (
  input  logic [DEPTH-1:0]    win_v,
  input  logic [DEPTH*QW-1:0] win_q,
  input  logic [Q*CW-1:0]     credit,
  input  logic [Q-1:0]        elig,
  output logic                found,
  output logic [QW-1:0]       sel_q,
  output logic [PW-1:0]       sel_pos
);
  localparam logic [PW-1:0] NONE = PW'(DEPTH);

  // Window position at which queue `who` first wants more than `have` cells.
  function automatic logic [PW-1:0] first_short(
    input logic [DEPTH-1:0]    v,
    input logic [DEPTH*QW-1:0] qs,
    input logic [QW-1:0]       who,
    input logic [CW-1:0]       have
  );
    logic [CW:0]     used;
    logic [PW-1:0]   pos;
    used = '0;
    pos  = NONE;
    for (int p = 0; p < DEPTH; p++) begin
      if (v[p] && qs[p*QW +: QW] == who) begin
        used = used + 1'b1;
        if (used > {1'b0, have} && pos == NONE) pos = PW'(p);
      end
    end
    return pos;
  endfunction

  logic [Q*PW-1:0] short_at;

  for (genvar gq = 0; gq < Q; gq++) begin : g_queue
    assign short_at[gq*PW +: PW] =
      first_short(win_v, win_q, QW'(gq), credit[gq*CW +: CW]);
  end

  // Earliest shortfall wins; strict compare keeps the lowest index on ties.
  always_comb begin
    found   = 1'b0;
    sel_q   = '0;
    sel_pos = NONE;
    for (int q = 0; q < Q; q++) begin
      if (elig[q] && short_at[q*PW +: PW] < sel_pos) begin
        sel_pos = short_at[q*PW +: PW];
        sel_q   = QW'(q);
        found   = 1'b1;
      end
    end
  end
endmodule

// File: rtl/lookahead_head_cache.sv
module lookahead_head_cache #(
  parameter int Q     = 4,
  parameter int B     = 4,
  parameter int CNT_W = 8,
  localparam int QW   = lacm_pkg::idx_w(Q)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arrive_valid,
  input  logic [QW-1:0] arrive_queue,
  input  logic          req_valid,
  input  logic [QW-1:0] req_queue,
  output logic          req_ready,
  output logic          disp_valid,
  output logic [QW-1:0] disp_queue,
  output logic          repl_valid,
  output logic [QW-1:0] repl_queue,
  input  logic          fill_valid,
  input  logic [QW-1:0] fill_queue,
  output logic          err_empty
);
  localparam int DEPTH = Q * (B - 1) + 1;
  localparam int PW    = $clog2(DEPTH + 1);
  localparam int CW    = CNT_W + 1;
  localparam int BW    = lacm_pkg::idx_w(B);
  localparam logic [CNT_W-1:0] BLK = CNT_W'(B);

  logic [CNT_W-1:0] cache_q [Q];
  logic [CNT_W-1:0] infl_q  [Q];
  logic [CNT_W-1:0] bulk_q  [Q];
  logic [CNT_W-1:0] avail_q [Q];
  logic [BW-1:0]    busy;

  logic [DEPTH-1:0]    win_v;
  logic [DEPTH*QW-1:0] win_q;
  logic [Q*CW-1:0]     credit;
  logic [Q-1:0]        elig;
  logic                pick_found;
  logic [QW-1:0]       pick_q;
  logic [PW-1:0]       pick_pos;

  // Named internal events, also observed by the checker.
  logic          accept;
  logic          head_v;
  logic [QW-1:0] head_q;
  logic          head_short;
  logic          issue;
  logic          tail_v;
  logic          win_any;
  logic          sel_bulk_ok;
  logic [Q-1:0]  fill_hit, issue_hit, arr_hit, acc_hit, use_hit;

  assign req_ready   = (avail_q[req_queue] != '0);
  assign accept      = req_valid && req_ready;
  assign head_v      = win_v[0];
  assign head_q      = win_q[QW-1:0];
  assign head_short  = head_v && (cache_q[head_q] == '0) &&
                       !(fill_valid && fill_queue == head_q);
  assign issue       = (busy == '0) && pick_found;
  assign tail_v      = win_v[DEPTH-1];
  assign win_any     = |win_v;
  assign sel_bulk_ok = (bulk_q[pick_q] >= BLK);

  assign disp_valid  = head_v;
  assign disp_queue  = head_q;
  assign repl_valid  = issue;
  assign repl_queue  = pick_q;

  lacm_window #(.DEPTH(DEPTH), .QW(QW)) window_i (
    .clk(clk), .rst_n(rst_n),
    .push_v(accept), .push_q(req_queue),
    .win_v(win_v), .win_q(win_q)
  );

  always_comb begin
    for (int q = 0; q < Q; q++) begin
      credit[q*CW +: CW] = {1'b0, cache_q[q]} + {1'b0, infl_q[q]};
      elig[q]      = (bulk_q[q] >= BLK);
      fill_hit[q]  = fill_valid   && (fill_queue   == QW'(q));
      issue_hit[q] = issue        && (pick_q       == QW'(q));
      arr_hit[q]   = arrive_valid && (arrive_queue == QW'(q));
      acc_hit[q]   = accept       && (req_queue    == QW'(q));
      use_hit[q]   = head_v && !head_short && (head_q == QW'(q));
    end
  end

  lacm_pick #(.Q(Q), .DEPTH(DEPTH), .QW(QW), .CW(CW), .PW(PW)) pick_i (
    .win_v(win_v), .win_q(win_q), .credit(credit), .elig(elig),
    .found(pick_found), .sel_q(pick_q), .sel_pos(pick_pos)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int q = 0; q < Q; q++) begin
        cache_q[q] <= '0;
        infl_q[q]  <= '0;
        bulk_q[q]  <= '0;
        avail_q[q] <= '0;
      end
      busy      <= '0;
      err_empty <= 1'b0;
    end else begin
      for (int q = 0; q < Q; q++) begin
        cache_q[q] <= cache_q[q] + (fill_hit[q] ? BLK : '0) - CNT_W'(use_hit[q]);
        infl_q[q]  <= infl_q[q] + (issue_hit[q] ? BLK : '0) - (fill_hit[q] ? BLK : '0);
        bulk_q[q]  <= bulk_q[q] + (arr_hit[q] ? BLK : '0) - (issue_hit[q] ? BLK : '0);
        avail_q[q] <= avail_q[q] + (arr_hit[q] ? BLK : '0) - CNT_W'(acc_hit[q]);
      end
      if (issue)             busy <= BW'(B - 1);
      else if (busy != '0)   busy <= busy - 1'b1;
      if (head_short)        err_empty <= 1'b1;
    end
  end
endmodule

module lookahead_head_cache_chk #(
  parameter int B  = 4,
  parameter int PW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          tail_v,
  input logic          win_any,
  input logic          repl_valid,
  input logic          sel_bulk_ok,
  input logic [PW-1:0] pick_pos,
  input logic          err_empty
);
  localparam int GW = $clog2(B + 1);
  logic [GW-1:0] gap;
  logic          seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (repl_valid) begin
      gap  <= '0;
      seen <= 1'b1;
    end else if (gap < GW'(B)) begin
      gap  <= gap + 1'b1;
    end
  end

  assert_reject_no_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> !tail_v);
  assert_idle_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !win_any |-> !repl_valid);
  assert_refill_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (repl_valid && seen) |-> (gap >= GW'(B - 1)));
  assert_refill_has_bulk_R7: assert property (@(posedge clk) disable iff (!rst_n)
    repl_valid |-> sel_bulk_ok);
  assert_refill_in_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    repl_valid |-> win_any && (pick_pos < PW'(B * 0 + (1 << PW) - 1)));
  assert_error_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_empty |=> err_empty);
endmodule

bind lookahead_head_cache lookahead_head_cache_chk #(.B(B), .PW(PW)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .tail_v(tail_v), .win_any(win_any), .repl_valid(repl_valid),
  .sel_bulk_ok(sel_bulk_ok), .pick_pos(pick_pos), .err_empty(err_empty)
);

// File: tb/lookahead_head_cache_tb.sv
module lookahead_head_cache_tb_top;
  localparam int Q  = 4;
  localparam int B  = 4;
  localparam int QW = 2;
  localparam int D  = Q * (B - 1) + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arrive_valid = 1'b0, req_valid = 1'b0, fill_valid = 1'b0;
  logic [QW-1:0] arrive_queue = '0, req_queue = '0, fill_queue = '0;
  logic req_ready, disp_valid, repl_valid, err_empty;
  logic [QW-1:0] disp_queue, repl_queue;

  always #5 clk = ~clk;

  lookahead_head_cache #(.Q(Q), .B(B), .CNT_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .arrive_valid(arrive_valid), .arrive_queue(arrive_queue),
    .req_valid(req_valid), .req_queue(req_queue), .req_ready(req_ready),
    .disp_valid(disp_valid), .disp_queue(disp_queue),
    .repl_valid(repl_valid), .repl_queue(repl_queue),
    .fill_valid(fill_valid), .fill_queue(fill_queue),
    .err_empty(err_empty)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  // Reference state, kept in the bench's own terms.
  int  m_cache[Q], m_infl[Q], m_bulk[Q], m_avail[Q];
  bit  m_wv[D];
  int  m_wq[D];
  int  m_busy, m_pend_q, arrivals[Q], refills[Q];
  bit  m_err, m_pend, drop_fill;
  bit  e_ready, e_rv;
  int  e_rq;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int q = 0; q < Q; q++) begin
      m_cache[q] = 0; m_infl[q] = 0; m_bulk[q] = 0; m_avail[q] = 0;
      arrivals[q] = 0; refills[q] = 0;
    end
    for (int i = 0; i < D; i++) begin m_wv[i] = 0; m_wq[i] = 0; end
    m_busy = 0; m_err = 0; m_pend = 0; m_pend_q = 0;
  endtask

  // Walk the window from the dispatch end, spending each queue's credit.
  task automatic expect_now();
    int rem[Q];
    e_ready = (m_avail[req_queue] > 0);
    e_rv = 0; e_rq = 0;
    for (int q = 0; q < Q; q++) rem[q] = m_cache[q] + m_infl[q];
    if (m_busy == 0) begin
      for (int i = 0; i < D; i++) begin
        if (m_wv[i] && m_bulk[m_wq[i]] >= B) begin
          rem[m_wq[i]]--;
          if (rem[m_wq[i]] < 0) begin e_rv = 1; e_rq = m_wq[i]; break; end
        end
      end
    end
  endtask

  task automatic model_step();
    bit acc, fh;
    int hq;
    acc = req_valid && (m_avail[req_queue] > 0);
    if (m_wv[0]) begin
      hq = m_wq[0];
      fh = fill_valid && (fill_queue == hq);
      if (m_cache[hq] == 0 && !fh) m_err = 1;
      else m_cache[hq]--;
    end
    if (fill_valid) begin m_cache[fill_queue] += B; m_infl[fill_queue] -= B; end
    if (e_rv) begin
      m_bulk[e_rq] -= B; m_infl[e_rq] += B; m_busy = B - 1; refills[e_rq]++;
    end else if (m_busy > 0) m_busy--;
    if (arrive_valid) begin
      m_bulk[arrive_queue] += B; m_avail[arrive_queue] += B; arrivals[arrive_queue]++;
    end
    if (acc) m_avail[req_queue]--;
    for (int i = 0; i < D - 1; i++) begin m_wv[i] = m_wv[i+1]; m_wq[i] = m_wq[i+1]; end
    m_wv[D-1] = acc; m_wq[D-1] = req_queue;
    m_pend = e_rv; m_pend_q = e_rq;
  endtask

  // One slot: drive inputs, compare before the edge, advance the model.
  task automatic slot(input bit av, input int aq, input bit rv, input int rq);
    arrive_valid = av; arrive_queue = QW'(aq);
    req_valid = rv; req_queue = QW'(rq);
    fill_valid = m_pend && !drop_fill; fill_queue = QW'(m_pend_q);
    #4;
    expect_now();
    check(req_ready == e_ready, "R2 req_ready", req_ready, e_ready);
    check(disp_valid == m_wv[0], "R3 disp_valid", disp_valid, m_wv[0]);
    if (m_wv[0]) check(disp_queue == m_wq[0], "R3 disp_queue", disp_queue, m_wq[0]);
    check(repl_valid == e_rv, "R4 R5 R6 repl_valid", repl_valid, e_rv);
    if (e_rv) check(repl_queue == e_rq, "R4 R8 repl_queue", repl_queue, e_rq);
    check(err_empty == m_err, "R9 err_empty", err_empty, m_err);
    model_step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    arrive_valid = 0; req_valid = 0; fill_valid = 0; drop_fill = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    model_reset();
    #2;
    check(!disp_valid && !repl_valid && !err_empty, "R1 outputs in reset", 
          {disp_valid, repl_valid, err_empty}, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Stimulus table: {arrive_valid, arrive_queue, req_valid, req_queue}.
  localparam logic [5:0] VEC [16] = '{
    6'b1_00_0_00, 6'b1_01_1_00, 6'b1_10_1_01, 6'b0_00_1_11,
    6'b0_00_1_00, 6'b0_00_1_10, 6'b0_00_0_00, 6'b0_00_1_01,
    6'b1_00_1_00, 6'b0_00_1_00, 6'b0_00_1_00, 6'b0_00_1_00,
    6'b0_00_1_11, 6'b0_00_1_01, 6'b0_00_0_00, 6'b0_00_1_10
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1: first slot after reset is quiet and nothing is available.
    #4;
    check(!disp_valid && !repl_valid && !err_empty && !req_ready,
          "R1 first slot", {disp_valid, repl_valid, err_empty, req_ready}, 0);
    @(negedge clk);

    // Table walk: mixed arrivals, accepted and rejected requests (R2 R3 R4).
    for (int i = 0; i < 16; i++)
      slot(VEC[i][5], int'(VEC[i][4:3]), VEC[i][2], int'(VEC[i][1:0]));
    for (int i = 0; i < D + 6; i++) slot(0, 0, 0, 0);

    // R2: queue 3 never received a block, so its requests never dispatch.
    check(arrivals[3] == 0 && refills[3] == 0, "R2 q3 untouched", refills[3], 0);

    // Single queue at full rate: refills must follow every B slots (R6 R8).
    for (int i = 0; i < 8; i++) slot(1, 1, 0, 0);
    for (int i = 0; i < 30; i++) slot(0, 0, 1, 1);
    for (int i = 0; i < D + 6; i++) slot(0, 0, 0, 0);
    // R5: window drained, nothing more requested.
    check(!repl_valid && !disp_valid, "R5 idle after drain", repl_valid, 0);

    // Round robin at full rate across all queues.
    for (int i = 0; i < 4 * Q; i++) slot(1, i % Q, 0, 0);
    for (int i = 0; i < 40; i++) slot(0, 0, 1, i % Q);
    for (int i = 0; i < D + 6; i++) slot(0, 0, 0, 0);

    // R7: refills per queue never exceed blocks written.
    for (int q = 0; q < Q; q++)
      check(refills[q] <= arrivals[q], "R7 refills within bulk", refills[q], arrivals[q]);

    // R9: withhold the refill, dispatch finds nothing, flag sticks.
    do_reset();
    drop_fill = 1;
    slot(1, 0, 0, 0);
    slot(0, 0, 1, 0);
    for (int i = 0; i < D + 3; i++) slot(0, 0, 0, 0);
    check(err_empty == 1, "R9 empty dispatch flagged", err_empty, 1);
    for (int i = 0; i < 5; i++) slot(0, 0, 0, 0);
    check(err_empty == 1, "R9 flag sticky", err_empty, 1);

    // R10: spaced random requests with a prompt responder.
    do_reset();
    for (int i = 0; i < 4 * Q; i++) slot(1, i % Q, 0, 0);
    for (int i = 0; i < 150; i++) begin
      int gap;
      slot(0, 0, 1, $urandom_range(Q - 1));
      gap = B - 1 + $urandom_range(3);
      for (int g = 0; g < gap; g++) slot(0, 0, 0, 0);
    end
    for (int i = 0; i < D + 6; i++) slot(0, 0, 0, 0);
    check(err_empty == 0, "R10 no empty dispatch", err_empty, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule